// File: doc/BRIEF.md
# Multi-format Serial Audio Receiver

This block takes stereo audio from a three-wire serial link (bit data, channel-select clock and bit clock) and turns it into one parallel left/right sample pair per frame. All of its logic runs on the master clock. The bit clock is either driven from outside the block or made inside it by dividing the master clock. The divide ratio follows from the master-clock-to-frame ratio and the data format. Serial data is two's complement, most significant bit first, and is sampled at the rising edge of the bit clock.

A static format code selects one of these layouts: the standard inter-IC sound layout, a left-justified layout of up to 24 bits, or a right-justified layout of 16, 18, 20 or 24 bits. Each word ends where the channel-select line changes level. Because of that, one edge detector closes words in every format. The format only decides which bits of the stream make up the word. A completed pair is presented with a one-cycle strobe and held until the next pair.

Top module: `sai_rx`

## Requirements
- R1: While reset is asserted, and after it until the first pair completes, `pair_valid_o` is 0 and both sample outputs are 0.
- R2: Right-justified codes 2, 3, 4 and 5 take the last 16, 18, 20 or 24 bits before a channel-select change as the word, MSB first, sign-extended to the output width. Codes 6 and 7 behave as code 5. A high channel-select level marks the left channel.
- R3: Code 0 (inter-IC sound layout) treats a low channel-select level as left. The MSB is in the second bit slot after the level change, and the word's last bit is in the first slot after the next change. At most 24 bits are kept, placed from bit 23 downward, and unfilled low bits read 0.
- R4: Code 1 (left-justified) treats a high channel-select level as left and takes the MSB from the first slot after the change. Bits past the 24th are ignored, and a shorter word leaves its low bits at 0.
- R5: With the internal bit clock, the bit slots per frame are 48 when `ratio_sel` is 1 (192) or 3 (384). For codes 0 and 2 they are 32 when `ratio_sel` is 0 (128), 2 (256) or 4 (512). In every other case they are 64. `ratio_sel` codes 5 to 7 act as 256.
- R6: With the internal bit clock, each slot lasts (ratio / slots-per-frame) master cycles, slot phase restarts at every channel-select change, and the bit is sampled in the middle of the slot.
- R7: With `ext_bclk_en` high, data and channel select are taken at each rising edge of `bclk_in` after synchronisation. Each bit-clock phase must last at least 2 master cycles.
- R8: `pair_valid_o` pulses for one cycle after a right word completes, and only if the left word of the same frame completed before it. The outputs hold their values between pulses.
- R9: The first word after reset is discarded, because its start was not observed. No pair is emitted until a complete left word has been followed by a complete right word.
- R10: In the right-justified codes, slots before the last W of a half-frame are ignored, whatever they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Static data layout code |
| ratio_sel | input | 3 | Static master-clock-to-frame ratio code |
| ext_bclk_en | input | 1 | 1 selects the external bit clock, 0 the internal divider |
| bclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | Channel-select clock |
| sdata_in | input | 1 | Serial data |
| left_o | output | OUT_W | Left sample of the last pair |
| right_o | output | OUT_W | Right sample of the last pair |
| pair_valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The bench builds the block with its defaults: OUT_W of 24, two synchroniser stages and a 5-bit divider counter. These values reach the longest slot of 16 master cycles, used for short frames at ratio 512, and the shortest of 2, used for 64-slot frames at ratio 128. Internal-clock runs cover every ratio code class and every format family. External-clock runs use frames of 24, 36 and 64 slots, which give short left-justified words, a right-justified word exactly filling its half-frame, and words that carry leading junk. A behavioural model predicts every pair, and every clock is checked for stray strobes and for outputs that change without a strobe.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

   // internal word width, all formats resolve to this before extension
   localparam int WORD_W = 24;
   localparam int RJ_N   = 4;
   localparam int RJ_WIDTHS [RJ_N] = '{16, 18, 20, 24};

   // layout codes (fmt_sel)
   localparam logic [2:0] FMT_I2S  = 3'd0;
   localparam logic [2:0] FMT_LJ   = 3'd1;
   localparam logic [2:0] FMT_RJ16 = 3'd2;
   localparam logic [2:0] FMT_RJ18 = 3'd3;
   localparam logic [2:0] FMT_RJ20 = 3'd4;

   // ratio codes (ratio_sel)
   localparam logic [2:0] RAT_128 = 3'd0;
   localparam logic [2:0] RAT_192 = 3'd1;
   localparam logic [2:0] RAT_384 = 3'd3;
   localparam logic [2:0] RAT_512 = 3'd4;

   // master cycles per internal bit slot
   function automatic logic [4:0] slot_div(input logic [2:0] fmt, input logic [2:0] ratio);
      logic short_frame;
      short_frame = (fmt == FMT_I2S) || (fmt == FMT_RJ16);
      case (ratio)
         RAT_128: slot_div = short_frame ? 5'd4  : 5'd2;
         RAT_192: slot_div = 5'd4;
         RAT_384: slot_div = 5'd8;
         RAT_512: slot_div = short_frame ? 5'd16 : 5'd8;
         default: slot_div = short_frame ? 5'd8  : 5'd4;
      endcase
   endfunction

   // index into RJ_WIDTHS for a right-justified code
   function automatic logic [1:0] rj_index(input logic [2:0] fmt);
      case (fmt)
         FMT_RJ16: rj_index = 2'd0;
         FMT_RJ18: rj_index = 2'd1;
         FMT_RJ20: rj_index = 2'd2;
         default:  rj_index = 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_chk_stages
      $error("sai_rx_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_chk_width
      $error("sai_rx_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sai_rx_bitclk.sv
module sai_rx_bitclk
   import sai_rx_pkg::*;
#(
   parameter int DIV_W = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ext_en_i,
   input  logic [2:0] fmt_i,
   input  logic [2:0] ratio_i,
   input  logic       bclk_s_i,
   input  logic       lrck_s_i,
   input  logic       data_s_i,
   output logic       tick_o,
   output logic       lr_o,
   output logic       bit_o
);

   if (DIV_W < 5) begin : g_chk_div
      $error("sai_rx_bitclk: DIV_W must hold a divide of 16");
   end

   logic             bclk_d_q, lrck_d_q;
   logic [DIV_W-1:0] cnt_q, phase, phase_nxt, n_val, n_half;
   logic             lr_edge, tick_int, tick_ext;

   assign n_val   = DIV_W'(slot_div(fmt_i, ratio_i));
   assign n_half  = n_val >> 1;
   assign lr_edge = lrck_s_i ^ lrck_d_q;

   always_comb begin
      phase     = lr_edge ? '0 : cnt_q;
      phase_nxt = (phase >= n_val - 1'b1) ? '0 : phase + 1'b1;
   end

   assign tick_int = (phase == n_half);
   assign tick_ext = bclk_s_i & ~bclk_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_d_q <= 1'b0;
         lrck_d_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         bclk_d_q <= bclk_s_i;
         lrck_d_q <= lrck_s_i;
         cnt_q    <= phase_nxt;
      end
   end

   assign tick_o = ext_en_i ? tick_ext : tick_int;
   assign lr_o   = lrck_s_i;
   assign bit_o  = data_s_i;

   // checker support: cycles between bit ticks
   logic [DIV_W:0] gap_q;
   logic           gap_ok_q, edge_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q       <= '0;
         gap_ok_q    <= 1'b0;
         edge_seen_q <= 1'b0;
      end else begin
         if (tick_o) begin
            gap_q       <= (DIV_W+1)'(1);
            gap_ok_q    <= 1'b1;
            edge_seen_q <= 1'b0;
         end else begin
            if (gap_q != '1) gap_q <= gap_q + 1'b1;
            if (lr_edge) edge_seen_q <= 1'b1;
         end
      end
   end

   // R7: a bit tick is never followed by another in the next cycle
   p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

   // R6: inside a half-frame, internal ticks are exactly one slot apart
   p_slot_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_en_i && tick_o && gap_ok_q && !edge_seen_q) |-> (gap_q == {1'b0, n_val}));

endmodule

// File: rtl/sai_rx_deser.sv
module sai_rx_deser
   import sai_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        fmt_i,
   input  logic              tick_i,
   input  logic              lr_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o,
   output logic              left_o
);

   localparam int POS_W = $clog2(WORD_W + 1);

   logic                       have_prev_q, lr_prev_q, open_q;
   logic [WORD_W-1:0]          acc_q, sh_q, word_q;
   logic [POS_W-1:0]           pos_q;
   logic                       done_q, left_q;
   logic [WORD_W-1:0]          acc_ins, bword;
   logic [RJ_N-1:0][WORD_W-1:0] rj_cand;
   logic                       boundary;

   // candidate right-justified words, one per supported width
   for (genvar g = 0; g < RJ_N; g++) begin : g_rj
      localparam int W = RJ_WIDTHS[g];
      if (W > WORD_W || W < 2) begin : g_chk
         $error("sai_rx_deser: right-justified width out of range");
      end else if (W == WORD_W) begin : g_full
         assign rj_cand[g] = sh_q;
      end else begin : g_ext
         assign rj_cand[g] = {{(WORD_W-W){sh_q[W-1]}}, sh_q[W-1:0]};
      end
   end

   assign boundary = tick_i && have_prev_q && (lr_i != lr_prev_q);
   assign acc_ins  = acc_q | ({bit_i, {(WORD_W-1){1'b0}}} >> pos_q);

   always_comb begin
      if (fmt_i == FMT_I2S)     bword = acc_ins;
      else if (fmt_i == FMT_LJ) bword = acc_q;
      else                      bword = rj_cand[rj_index(fmt_i)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev_q <= 1'b0;
         lr_prev_q   <= 1'b0;
         open_q      <= 1'b0;
         acc_q       <= '0;
         sh_q        <= '0;
         pos_q       <= '0;
         word_q      <= '0;
         done_q      <= 1'b0;
         left_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick_i) begin
            have_prev_q <= 1'b1;
            lr_prev_q   <= lr_i;
            sh_q        <= {sh_q[WORD_W-2:0], bit_i};
            if (boundary) begin
               open_q <= 1'b1;
               done_q <= open_q;
               word_q <= bword;
               left_q <= (fmt_i == FMT_I2S) ? ~lr_prev_q : lr_prev_q;
               if (fmt_i == FMT_I2S) begin
                  acc_q <= '0;
                  pos_q <= '0;
               end else begin
                  acc_q <= {bit_i, {(WORD_W-1){1'b0}}};
                  pos_q <= POS_W'(1);
               end
            end else begin
               acc_q <= acc_ins;
               if (pos_q != POS_W'(WORD_W)) pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

   assign word_o = word_q;
   assign done_o = done_q;
   assign left_o = left_q;

   // R9: a completed word is always the result of a bit tick
   p_done_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(tick_i));

endmodule

// File: rtl/sai_rx_pair.sv
module sai_rx_pair
   import sai_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              done_i,
   input  logic              left_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o
);

   logic [WORD_W-1:0] hold_q, left_q, right_q;
   logic              have_left_q, valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         left_q      <= '0;
         right_q     <= '0;
         have_left_q <= 1'b0;
         valid_q     <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (done_i) begin
            if (left_i) begin
               hold_q      <= word_i;
               have_left_q <= 1'b1;
            end else if (have_left_q) begin
               left_q      <= hold_q;
               right_q     <= word_i;
               valid_q     <= 1'b1;
               have_left_q <= 1'b0;
            end
         end
      end
   end

   assign left_o  = left_q;
   assign right_o = right_q;
   assign valid_o = valid_q;

   // R8: strobe lasts a single cycle
   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   // R8: strobe only follows a completed right word
   p_valid_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(done_i && !left_i));

   // R8: outputs hold between strobes
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> ($stable(left_q) && $stable(right_q)));

endmodule

// File: rtl/sai_rx.sv
module sai_rx
   import sai_rx_pkg::*;
#(
   parameter int OUT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_W       = 5
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic [2:0]       fmt_sel,
   input  logic [2:0]       ratio_sel,
   input  logic             ext_bclk_en,
   input  logic             bclk_in,
   input  logic             lrck_in,
   input  logic             sdata_in,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             pair_valid_o
);

   if (OUT_W < WORD_W) begin : g_chk_out
      $error("sai_rx: OUT_W must be at least WORD_W");
   end

   logic [2:0]        pins_s;
   logic              tick, lr_bit, data_bit;
   logic [WORD_W-1:0] word, pl, pr;
   logic              word_done, word_left;

   sai_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (mclk),
      .rst_n (rst_n),
      .d_i   ({bclk_in, lrck_in, sdata_in}),
      .q_o   (pins_s)
   );

   sai_rx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
      .clk      (mclk),
      .rst_n    (rst_n),
      .ext_en_i (ext_bclk_en),
      .fmt_i    (fmt_sel),
      .ratio_i  (ratio_sel),
      .bclk_s_i (pins_s[2]),
      .lrck_s_i (pins_s[1]),
      .data_s_i (pins_s[0]),
      .tick_o   (tick),
      .lr_o     (lr_bit),
      .bit_o    (data_bit)
   );

   sai_rx_deser u_deser (
      .clk    (mclk),
      .rst_n  (rst_n),
      .fmt_i  (fmt_sel),
      .tick_i (tick),
      .lr_i   (lr_bit),
      .bit_i  (data_bit),
      .word_o (word),
      .done_o (word_done),
      .left_o (word_left)
   );

   sai_rx_pair u_pair (
      .clk     (mclk),
      .rst_n   (rst_n),
      .word_i  (word),
      .done_i  (word_done),
      .left_i  (word_left),
      .left_o  (pl),
      .right_o (pr),
      .valid_o (pair_valid_o)
   );

   if (OUT_W == WORD_W) begin : g_out_direct
      assign left_o  = pl;
      assign right_o = pr;
   end else begin : g_out_sext
      assign left_o  = {{(OUT_W-WORD_W){pl[WORD_W-1]}}, pl};
      assign right_o = {{(OUT_W-WORD_W){pr[WORD_W-1]}}, pr};
   end

endmodule

// File: tb/sai_rx_tb.sv
module sai_rx_tb;

   localparam int OUT_W = 24;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n = 1'b0;
   logic [2:0]       fmt = 3'd0, ratio = 3'd0;
   logic             ext_en = 1'b0, bclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
   logic [OUT_W-1:0] l_o, r_o;
   logic             v_o;

   sai_rx #(.OUT_W(OUT_W)) u_dut (
      .mclk(clk), .rst_n(rst_n), .fmt_sel(fmt), .ratio_sel(ratio),
      .ext_bclk_en(ext_en), .bclk_in(bclk), .lrck_in(lrck), .sdata_in(sdata),
      .left_o(l_o), .right_o(r_o), .pair_valid_o(v_o)
   );

   int n_vec = 0, n_bad = 0, n_seen = 0;
   string cur_req = "R1";
   logic [OUT_W-1:0] exp_l[$], exp_r[$];
   logic [OUT_W-1:0] last_l = '0, last_r = '0;

   task automatic check(string req, string what, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!rst_n) begin
         last_l = '0;
         last_r = '0;
      end else if (v_o) begin
         n_seen++;
         if (exp_l.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL %s/R9 stray strobe: actual pair %h %h expected none", cur_req, l_o, r_o);
         end else begin
            check(cur_req, "left",  l_o, exp_l.pop_front());
            check(cur_req, "right", r_o, exp_r.pop_front());
         end
         last_l = l_o;
         last_r = r_o;
      end else begin
         check("R8", "left hold",  l_o, last_l);
         check("R8", "right hold", r_o, last_r);
      end
   end

   function automatic int ratio_val(logic [2:0] r);
      case (r)
         3'd0: return 128;
         3'd1: return 192;
         3'd3: return 384;
         3'd4: return 512;
         default: return 256;
      endcase
   endfunction

   function automatic int slots_frame(logic [2:0] f, logic [2:0] r);
      if (r == 3'd1 || r == 3'd3) return 48;
      if ((f == 3'd0 || f == 3'd2) && (r == 3'd0 || r == 3'd2 || r == 3'd4)) return 32;
      return 64;
   endfunction

   function automatic int rj_w(logic [2:0] f);
      case (f)
         3'd2: return 16;
         3'd3: return 18;
         3'd4: return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [OUT_W-1:0] expect_word(logic [2:0] f, logic [23:0] smp, int s);
      logic [23:0] m;
      int w, nb;
      if (f <= 3'd1) begin
         nb = (s < 24) ? s : 24;
         m = '0;
         for (int i = 0; i < nb; i++) m[23-i] = 1'b1;
         return OUT_W'(smp & m);
      end
      w = rj_w(f);
      m = smp;
      for (int i = w; i < 24; i++) m[i] = smp[w-1];
      return OUT_W'(m);
   endfunction

   function automatic logic [63:0] make_bits(logic [2:0] f, logic [23:0] smp, int s, inout bit carry);
      logic [63:0] b;
      int w, j;
      b = {$urandom, $urandom};
      if (f == 3'd0) begin
         b[0] = carry;
         for (int k = 1; k < s; k++) if (k - 1 < 24) b[k] = smp[24-k];
         carry = (s - 1 < 24) ? smp[24-s] : 1'b0;
      end else if (f == 3'd1) begin
         for (int k = 0; k < s && k < 24; k++) b[k] = smp[23-k];
      end else begin
         w = rj_w(f);
         for (int k = 0; k < s; k++) begin
            j = k - (s - w);
            if (j >= 0) b[k] = smp[w-1-j];
         end
      end
      return b;
   endfunction

   task automatic send_half(bit level, logic [63:0] b, int s, bit ext, int n, int hp);
      for (int k = 0; k < s; k++) begin
         lrck  = level;
         sdata = b[k];
         if (ext) begin
            bclk = 1'b0;
            repeat (hp) @(negedge clk);
            bclk = 1'b1;
            repeat (hp) @(negedge clk);
         end else begin
            repeat (n) @(negedge clk);
         end
      end
   endtask

   task automatic run_case(string req, logic [2:0] f, logic [2:0] r, bit ext, int hp,
                           int spf_ext, int nfr);
      int spf, n, s;
      bit left_lvl, carry;
      logic [23:0] sl, sr;
      logic [63:0] b;
      cur_req = req;
      spf = ext ? spf_ext : slots_frame(f, r);
      n   = ratio_val(r) / spf;
      s   = spf / 2;
      left_lvl = (f == 3'd0) ? 1'b0 : 1'b1;
      @(negedge clk);
      rst_n = 1'b0; fmt = f; ratio = r; ext_en = ext;
      bclk = 1'b0; lrck = ~left_lvl; sdata = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      n_seen = 0;
      repeat (2) @(negedge clk);
      carry = 1'b0;
      send_half(~left_lvl, 64'h0, s, ext, n, hp);
      for (int fr = 0; fr < nfr; fr++) begin
         sl = 24'($urandom);
         sr = 24'($urandom);
         exp_l.push_back(expect_word(f, sl, s));
         exp_r.push_back(expect_word(f, sr, s));
         b = make_bits(f, sl, s, carry);
         send_half(left_lvl, b, s, ext, n, hp);
         b = make_bits(f, sr, s, carry);
         send_half(~left_lvl, b, s, ext, n, hp);
      end
      b = 64'h0;
      b[0] = carry;
      send_half(left_lvl, b, s, ext, n, hp);
      repeat (20) @(negedge clk);
      check({req, "/R9"}, "pair count", OUT_W'(n_seen), OUT_W'(nfr));
      check({req, "/R8"}, "pending pairs", OUT_W'(exp_l.size()), '0);
      exp_l.delete();
      exp_r.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "left at reset",  l_o, '0);
      check("R1", "right at reset", r_o, '0);
      check("R1", "valid at reset", OUT_W'(v_o), '0);
      // internal bit clock
      run_case("R3/R5/R6 i2s int 256",  3'd0, 3'd2, 1'b0, 0, 0, 3);
      run_case("R3/R5 i2s int 384",     3'd0, 3'd3, 1'b0, 0, 0, 3);
      run_case("R4/R5 lj int 128",      3'd1, 3'd0, 1'b0, 0, 0, 3);
      run_case("R2/R5 rj16 int 512",    3'd2, 3'd4, 1'b0, 0, 0, 3);
      run_case("R2/R10 rj20 int 192",   3'd4, 3'd1, 1'b0, 0, 0, 3);
      run_case("R2/R10 rj18 int 256",   3'd3, 3'd2, 1'b0, 0, 0, 3);
      run_case("R2/R5 code7 int code6", 3'd7, 3'd6, 1'b0, 0, 0, 3);
      // external bit clock
      run_case("R7/R2 rj18 ext 36",     3'd3, 3'd2, 1'b1, 2, 36, 3);
      run_case("R7/R10 rj24 ext 64",    3'd5, 3'd2, 1'b1, 3, 64, 3);
      run_case("R7/R4 lj ext 24",       3'd1, 3'd2, 1'b1, 2, 24, 3);
      run_case("R7/R3 i2s ext 64",      3'd0, 3'd2, 1'b1, 2, 64, 3);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule